// File: doc/BRIEF.md
# Serial-Bus Identification Memory Slave

This block is the two-wire serial-bus slave of a 256-byte identification memory on a memory module. It oversamples the clock and data lines with the system clock and finds start and stop conditions. It compares the addressed device against a fixed device type and three strap inputs. It then serves byte writes and three kinds of read: current-address, random and sequential. The data line is open-drain. The block therefore drives it through a separate level (`sda_o`) and enable (`sda_oe_o`), and the board resolves the bus as a wired-AND with the master.

A single word-address register persists from one transaction to the next. A write is held until the master closes the transaction with a stop. The write then lands in the internal register array, a one-cycle strobe is raised, and a busy window runs. During that window the slave refuses its address.

A second device type, `0110`, addresses a one-time lock that freezes the lower half of the array. A pin input freezes the upper half for as long as it is high.

Top module: `eep_slave`

## Requirements
- R1: After reset the slave does not drive SDA and busy is low. Bits clocked without a preceding start (SDA falling while SCL is high) are ignored, so the ninth clock shows no acknowledge.
- R2: An address byte is accepted only when bits 7..4 equal `1010` (memory) or `0110` (lock) and bits 3..1 equal `strap_i`. The slave then pulls SDA low during the ninth clock. For any other byte it leaves SDA released.
- R3: A memory write (bit 0 of the address byte = 0) is acknowledged on its address byte, its word-address byte and its data byte. The data is stored only when a stop (SDA rising while SCL is high) follows the data byte. Each such store raises `wr_strobe_o` for exactly one clock.
- R4: A start that follows the data byte in place of a stop discards the write. No strobe is raised and the location keeps its old value.
- R5: A current read (address byte with bit 0 = 1) returns the byte at the last written address n. After a read of address n, it returns the byte at n+1.
- R6: A random read writes the word address, then issues a repeated start with bit 0 = 1, and returns the byte at that word address.
- R7: A low master acknowledge after a read byte, with no stop, makes the slave send the next address's byte. The address wraps from FFh to 00h.
- R8: A high master acknowledge after a read byte makes the slave release SDA and stay silent until the next start.
- R9: A store keeps `busy_o` high for WR_CYCLES clocks, and the strobe lies inside that window. An address byte received while busy is not acknowledged. Once busy falls, the address is accepted again.
- R10: The lock command is address `0110` + strap + bit 0 = 0, followed by two don't-care bytes and a stop. It permanently blocks stores to addresses 00h..7Fh, and a blocked store leaves the data unchanged with no strobe. Once the lock is set, its address byte is no longer acknowledged.
- R11: While `wp_i` is high, stores to 80h..FFh are dropped with no strobe. While it is low, they proceed.
- R12: SDA is sampled on rising SCL. The slave changes its drive only after a falling SCL edge, so its SDA level is stable while SCL is high.
- R13: A start or stop in the middle of a byte abandons the transaction. No store takes place, and a following transaction is decoded from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level as seen on the bus |
| strap_i | input | 3 | Board straps compared with address bits 3..1 |
| wp_i | input | 1 | High blocks stores to the upper half of the array |
| sda_o | output | 1 | Level the slave drives onto SDA when enabled |
| sda_oe_o | output | 1 | SDA drive enable |
| wr_strobe_o | output | 1 | One-clock pulse when a byte is stored in the array |
| busy_o | output | 1 | High while the internal write window runs |

## Verification
The bench builds the block with WR_CYCLES = 400, two synchronizer stages and the full 8-bit address. Each bus quarter-bit lasts five clocks. With these values a new address byte arrives well inside the busy window, so the refusal under R9 can be observed. The window is also short enough that many stores, the lock command and the later blocked stores all fit in one run. Because the address is a full byte, a sequential read started at FEh crosses the FFh-to-00h wrap.

// File: rtl/eep_pkg.sv
package eep_pkg;
    localparam int BYTE_W = 8;
    localparam logic [3:0] DEV_MEM  = 4'b1010;
    localparam logic [3:0] DEV_LOCK = 4'b0110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_WORD,
        ST_WDATA,
        ST_ACK,
        ST_WAIT_STOP,
        ST_RDATA,
        ST_RACK
    } link_st_e;

    typedef enum logic {
        K_MEM,
        K_LOCK
    } target_e;
endpackage

// File: rtl/eep_bus_cond.sv
module eep_bus_cond #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic [SYNC-1:0] scl_sh;
        logic [SYNC-1:0] sda_sh;
        logic            scl_p;
        logic            sda_p;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d = q;
        d.scl_sh = {q.scl_sh[SYNC-2:0], scl_i};
        d.sda_sh = {q.sda_sh[SYNC-2:0], sda_i};
        d.scl_p  = q.scl_sh[SYNC-1];
        d.sda_p  = q.sda_sh[SYNC-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_o      = q.scl_sh[SYNC-1];
    assign sda_o      = q.sda_sh[SYNC-1];
    assign scl_rise_o = scl_o && !q.scl_p;
    assign scl_fall_o = !scl_o && q.scl_p;
    assign start_o    = scl_o && q.scl_p && q.sda_p && !sda_o;
    assign stop_o     = scl_o && q.scl_p && !q.sda_p && sda_o;

    // R1
    start_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> $past(scl_o));
endmodule

// File: rtl/eep_store.sv
module eep_store
    import eep_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int WR_CYCLES = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_mem_i,
    input  logic              commit_lock_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    input  logic              wp_i,
    output logic [BYTE_W-1:0] rdata_o,
    output logic              busy_o,
    output logic              strobe_o,
    output logic              locked_o
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int TW    = $clog2(WR_CYCLES + 1);

    typedef struct packed {
        logic [TW-1:0] timer;
        logic          locked;
        logic          strobe;
    } store_t;

    store_t q, d;
    logic [BYTE_W-1:0] mem_q [DEPTH];
    logic blocked;
    logic do_write;

    always_comb begin
        blocked  = waddr_i[ADDR_W-1] ? wp_i : q.locked;
        do_write = commit_mem_i && !blocked;
        d        = q;
        d.strobe = do_write;
        if (q.timer != '0) d.timer = q.timer - 1'b1;
        if (do_write || (commit_lock_i && !q.locked)) d.timer = TW'(WR_CYCLES);
        if (commit_lock_i) d.locked = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (do_write) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o  = mem_q[raddr_i];
    assign busy_o   = (q.timer != '0);
    assign strobe_o = q.strobe;
    assign locked_o = q.locked;

    // R9
    strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> busy_o);

    // R10
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |=> locked_o);

    // R11
    wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_mem_i && waddr_i[ADDR_W-1] && wp_i) |=> !strobe_o);
endmodule

// File: rtl/eep_slave.sv
module eep_slave
    import eep_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int WR_CYCLES = 2000,
    parameter int SYNC      = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    input  logic       wp_i,
    output logic       sda_o,
    output logic       sda_oe_o,
    output logic       wr_strobe_o,
    output logic       busy_o
);
    localparam logic [3:0] BITS_FULL = 4'd8;

    typedef struct packed {
        link_st_e          st;
        link_st_e          nxt;
        target_e           kind;
        logic [3:0]        cnt;
        logic [BYTE_W-1:0] sh;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] wdat;
        logic              mack;
        logic              oe;
        logic              sdo;
        logic              cmt_mem;
        logic              cmt_lock;
    } link_t;

    link_t q, d;

    logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
    logic [BYTE_W-1:0] rdata;
    logic busy, locked;
    logic byte_end, strap_ok, do_load;

    eep_bus_cond #(.SYNC(SYNC)) u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start),
        .stop_o     (stop)
    );

    eep_store #(.ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES)) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .commit_mem_i  (q.cmt_mem),
        .commit_lock_i (q.cmt_lock),
        .waddr_i       (q.addr),
        .wdata_i       (q.wdat),
        .raddr_i       (q.addr),
        .wp_i          (wp_i),
        .rdata_o       (rdata),
        .busy_o        (busy),
        .strobe_o      (wr_strobe_o),
        .locked_o      (locked)
    );

    always_comb begin
        d          = q;
        d.cmt_mem  = 1'b0;
        d.cmt_lock = 1'b0;
        do_load    = 1'b0;
        byte_end   = scl_fall && (q.cnt == BITS_FULL);
        strap_ok   = (q.sh[3:1] == strap_i);

        if (start) begin
            d.st  = ST_DEV;
            d.cnt = '0;
            d.oe  = 1'b0;
            d.sdo = 1'b1;
        end else if (stop) begin
            if (q.st == ST_WAIT_STOP) begin
                d.cmt_mem  = (q.kind == K_MEM);
                d.cmt_lock = (q.kind == K_LOCK);
            end
            d.st  = ST_IDLE;
            d.oe  = 1'b0;
            d.sdo = 1'b1;
        end else begin
            unique case (q.st)
                ST_DEV, ST_WORD, ST_WDATA: begin
                    if (scl_rise && q.cnt < BITS_FULL) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end else if (byte_end) begin
                        d.cnt = '0;
                        d.st  = ST_ACK;
                        d.oe  = 1'b1;
                        d.sdo = 1'b0;
                        if (q.st == ST_DEV) begin
                            if (strap_ok && q.sh[7:4] == DEV_MEM && !busy) begin
                                d.kind = K_MEM;
                                d.nxt  = q.sh[0] ? ST_RDATA : ST_WORD;
                            end else if (strap_ok && q.sh[7:4] == DEV_LOCK && !q.sh[0]
                                         && !busy && !locked) begin
                                d.kind = K_LOCK;
                                d.nxt  = ST_WORD;
                            end else begin
                                d.st  = ST_IDLE;
                                d.oe  = 1'b0;
                                d.sdo = 1'b1;
                            end
                        end else if (q.st == ST_WORD) begin
                            if (q.kind == K_MEM) d.addr = q.sh[ADDR_W-1:0];
                            d.nxt = ST_WDATA;
                        end else begin
                            d.wdat = q.sh;
                            d.nxt  = ST_WAIT_STOP;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (q.nxt == ST_RDATA) begin
                            do_load = 1'b1;
                        end else begin
                            d.st  = q.nxt;
                            d.oe  = 1'b0;
                            d.sdo = 1'b1;
                            d.cnt = '0;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (q.cnt == 4'd7) begin
                            d.oe  = 1'b0;
                            d.sdo = 1'b1;
                            d.cnt = '0;
                            d.st  = ST_RACK;
                        end else begin
                            d.sh  = {q.sh[BYTE_W-2:0], 1'b0};
                            d.sdo = q.sh[BYTE_W-2];
                            d.cnt = q.cnt + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) d.mack = !sda_s;
                    if (scl_fall) begin
                        if (q.mack) do_load = 1'b1;
                        else        d.st = ST_IDLE;
                    end
                end
                ST_WAIT_STOP: begin
                    if (scl_fall) d.st = ST_IDLE;
                end
                default: ;
            endcase
        end

        if (do_load) begin
            d.sh   = rdata;
            d.addr = q.addr + 1'b1;
            d.sdo  = rdata[BYTE_W-1];
            d.oe   = 1'b1;
            d.cnt  = '0;
            d.st   = ST_RDATA;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.nxt  <= ST_IDLE;
            q.kind <= K_MEM;
            q.sdo  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sda_o    = q.sdo;
    assign sda_oe_o = q.oe;
    assign busy_o   = busy;

    // R12
    drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(start) && !$past(stop))
        |-> $stable({sda_oe_o, sda_o}));

    // R3
    commit_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cmt_mem |=> !q.cmt_mem);

    // R9
    busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DEV && byte_end && busy && !start && !stop) |=> !sda_oe_o);

    // R10
    commit_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q.cmt_mem, q.cmt_lock}));
endmodule

// File: tb/eep_slave_bench.sv
module eep_slave_bench;
    localparam int Q     = 5;
    localparam int WR    = 400;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] DEV_W  = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] DEV_R  = {4'b1010, STRAP, 1'b1};
    localparam logic [7:0] LOCK_W = {4'b0110, STRAP, 1'b0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic wp = 1'b0;
    logic sda_o, sda_oe, wr_strobe, busy;
    logic sda_bus;
    int strobe_cnt = 0;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    string tag_q[$];
    int    exp_q[$];
    int    obs_q[$];
    event  obs_ev;

    always #5 clk = ~clk;

    assign sda_bus = m_sda & (sda_oe ? sda_o : 1'b1);

    eep_slave #(.ADDR_W(8), .WR_CYCLES(WR), .SYNC(2)) u_eep_slave (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (m_scl),
        .sda_i       (sda_bus),
        .strap_i     (STRAP),
        .wp_i        (wp),
        .sda_o       (sda_o),
        .sda_oe_o    (sda_oe),
        .wr_strobe_o (wr_strobe),
        .busy_o      (busy)
    );

    always @(posedge clk) if (rst_n && wr_strobe) strobe_cnt <= strobe_cnt + 1;

    function automatic void drain();
        while (obs_q.size() != 0 && exp_q.size() != 0) begin
            int o = obs_q.pop_front();
            int e = exp_q.pop_front();
            string t = tag_q.pop_front();
            total++;
            if (o != e) begin
                bad++;
                $display("FAIL %s actual=%0h expected=%0h", t, o, e);
            end
        end
    endfunction

    always @(obs_ev) drain();

    task automatic check(input string tag, input int exp, input int act);
        tag_q.push_back(tag);
        exp_q.push_back(exp);
        obs_q.push_back(act);
        ->obs_ev;
    endtask

    task automatic summary();
        drain();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic bit_out(input logic b);
        tick(Q); m_sda = b; tick(Q); m_scl = 1'b1; tick(2 * Q); m_scl = 1'b0;
    endtask

    task automatic bit_in(output logic v, output logic steady);
        logic a;
        m_sda = 1'b1; tick(2 * Q); m_scl = 1'b1; tick(Q); a = sda_bus;
        tick(Q); v = sda_bus; steady = (a == v); m_scl = 1'b0;
    endtask

    task automatic bus_start();
        tick(Q); m_sda = 1'b0; tick(Q); m_scl = 1'b0;
    endtask

    task automatic bus_rstart();
        tick(Q); m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b0; tick(Q); m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        tick(Q); m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic st;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(ack, st);
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic mack);
        logic b, st;
        logic all_st = 1'b1;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            bit_in(b, st);
            v = {v[6:0], b};
            all_st &= st;
        end
        check("R12 slave level held while SCL high", 1, all_st);
        bit_out(mack);
    endtask

    task automatic write_byte(input string tag, input logic [7:0] a, input logic [7:0] dv,
                              input int exp_strobes);
        logic ack;
        int s0;
        bus_start();
        send_byte(DEV_W, ack); check({tag, " address ack"}, 0, ack);
        send_byte(a, ack);     check({tag, " word ack"}, 0, ack);
        send_byte(dv, ack);    check({tag, " data ack"}, 0, ack);
        s0 = strobe_cnt;
        bus_stop();
        tick(Q);
        check({tag, " strobe count"}, exp_strobes, strobe_cnt - s0);
        tick(WR + 50);
    endtask

    task automatic open_read_at(input string tag, input logic [7:0] a);
        logic ack;
        bus_start();
        send_byte(DEV_W, ack); check({tag, " dummy address ack"}, 0, ack);
        send_byte(a, ack);     check({tag, " dummy word ack"}, 0, ack);
        bus_rstart();
        send_byte(DEV_R, ack); check({tag, " read address ack"}, 0, ack);
    endtask

    task automatic read_one(input string tag, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] v;
        open_read_at(tag, a);
        recv_byte(v, 1'b1);
        check({tag, " data"}, exp, v);
        bus_stop();
    endtask

    initial begin
        logic ack;
        logic [7:0] v;
        int s0;

        tick(5);
        check("R1 reset drive enable", 0, sda_oe);
        check("R1 reset busy", 0, busy);
        rst_n = 1'b1;
        tick(5);
        check("R1 idle strobe count", 0, strobe_cnt);

        // R1: a byte clocked with no start gets no acknowledge
        m_scl = 1'b0;
        send_byte(DEV_W, ack);
        check("R1 no ack without start", 1, ack);
        tick(Q); m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(2 * Q);
        check("R1 no drive without start", 0, sda_oe);

        // R2: wrong strap and wrong device type are ignored
        bus_start();
        send_byte({4'b1010, 3'b010, 1'b0}, ack);
        check("R2 strap mismatch nack", 1, ack);
        bus_stop();
        bus_start();
        send_byte({4'b1100, STRAP, 1'b0}, ack);
        check("R2 device type mismatch nack", 1, ack);
        bus_stop();

        // R9: busy window refuses the address, then accepts again
        bus_start();
        send_byte(DEV_W, ack); check("R3 address ack", 0, ack);
        send_byte(8'h40, ack); check("R3 word ack", 0, ack);
        send_byte(8'h3C, ack); check("R3 data ack", 0, ack);
        s0 = strobe_cnt;
        bus_stop();
        tick(Q);
        check("R3 one strobe on stop", 1, strobe_cnt - s0);
        check("R9 busy after store", 1, busy);
        bus_start();
        send_byte(DEV_W, ack);
        check("R9 nack while busy", 1, ack);
        bus_stop();
        tick(WR + 50);
        check("R9 busy cleared", 0, busy);
        bus_start();
        send_byte(DEV_W, ack);
        check("R9 ack after busy", 0, ack);
        bus_stop();
        read_one("R3 readback 40", 8'h40, 8'h3C);

        // R5 / R6
        write_byte("R3 w10", 8'h10, 8'h5A, 1);
        write_byte("R3 w11", 8'h11, 8'hC3, 1);
        bus_start();
        send_byte(DEV_R, ack); check("R5 current read ack", 0, ack);
        recv_byte(v, 1'b1);
        check("R5 current read after write at n", 8'hC3, v);
        bus_stop();
        read_one("R6 random read 10", 8'h10, 8'h5A);
        bus_start();
        send_byte(DEV_R, ack); check("R5 current read ack 2", 0, ack);
        recv_byte(v, 1'b1);
        check("R5 current read after read at n gives n+1", 8'hC3, v);
        // R8: after master nack the slave lets go of the line
        tick(2 * Q);
        check("R8 released after master nack", 0, sda_oe);
        check("R8 bus high after master nack", 1, sda_bus);
        bus_stop();

        // R7: sequential read across the FFh wrap
        write_byte("R3 wFF", 8'hFF, 8'hEE, 1);
        write_byte("R3 w00", 8'h00, 8'h11, 1);
        open_read_at("R7 seq", 8'hFE);
        recv_byte(v, 1'b0); check("R7 seq byte FE", 8'h00, v);
        recv_byte(v, 1'b0); check("R7 seq byte FF", 8'hEE, v);
        recv_byte(v, 1'b1); check("R7 seq wraps to 00", 8'h11, v);
        bus_stop();

        // R4: start in place of stop discards the write
        s0 = strobe_cnt;
        bus_start();
        send_byte(DEV_W, ack); check("R4 address ack", 0, ack);
        send_byte(8'h20, ack); check("R4 word ack", 0, ack);
        send_byte(8'h77, ack); check("R4 data ack", 0, ack);
        bus_rstart();
        send_byte(DEV_R, ack); check("R4 read ack after restart", 0, ack);
        recv_byte(v, 1'b1);
        check("R4 location unchanged", 8'h00, v);
        bus_stop();
        check("R4 no strobe", 0, strobe_cnt - s0);

        // R13: stop and start in the middle of a byte
        s0 = strobe_cnt;
        bus_start();
        send_byte(DEV_W, ack); check("R13 address ack", 0, ack);
        send_byte(8'h30, ack); check("R13 word ack", 0, ack);
        for (int i = 0; i < 4; i++) bit_out(1'b1);
        bus_stop();
        tick(Q);
        check("R13 no strobe after mid-byte stop", 0, strobe_cnt - s0);
        check("R13 no busy after mid-byte stop", 0, busy);
        bus_start();
        for (int i = 7; i >= 5; i--) bit_out(DEV_W[i]);
        bus_rstart();
        send_byte(DEV_R, ack); check("R13 ack after mid-byte start", 0, ack);
        recv_byte(v, 1'b1);
        check("R13 location 30 untouched", 8'h00, v);
        bus_stop();

        // R11: pin protection of the upper half
        wp = 1'b1;
        write_byte("R11 blocked w90", 8'h90, 8'h42, 0);
        read_one("R11 blocked read 90", 8'h90, 8'h00);
        write_byte("R11 lower half open w12", 8'h12, 8'h34, 1);
        wp = 1'b0;
        write_byte("R11 open w90", 8'h90, 8'h42, 1);
        read_one("R11 open read 90", 8'h90, 8'h42);

        // R10: one-time lock of the lower half
        write_byte("R10 pre-lock w05", 8'h05, 8'h99, 1);
        bus_start();
        send_byte(LOCK_W, ack); check("R10 lock address ack", 0, ack);
        send_byte(8'h00, ack);  check("R10 lock byte 1 ack", 0, ack);
        send_byte(8'hA5, ack);  check("R10 lock byte 2 ack", 0, ack);
        bus_stop();
        tick(WR + 50);
        write_byte("R10 locked w05", 8'h05, 8'h11, 0);
        read_one("R10 locked read 05", 8'h05, 8'h99);
        write_byte("R10 upper w85", 8'h85, 8'h21, 1);
        read_one("R10 upper read 85", 8'h85, 8'h21);
        bus_start();
        send_byte(LOCK_W, ack);
        check("R10 second lock refused", 1, ack);
        bus_stop();

        tick(20);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end
endmodule